// File: doc/BRIEF.md
# Aperture address remapping table

This block remaps requests that land inside a fixed address window onto physical pages. It holds one entry per 4 KiB page of the window. Each entry carries a valid flag and a physical page-frame number. A request outside the window always faults. So does a request that selects an invalid entry, and so does any request made while translation is switched off. The window base address and the number of entries are parameters.

Software does not see the table directly. It reaches the table through three 32-bit registers:

- **Control register** (offset 0x0): holds the enable bit.
- **Page-select register** (offset 0x4): software writes the byte address of a page inside the window here.
- **Entry-data register** (offset 0x8): writes and reads go to the entry named by page-select.

The control register can be read back, so software can use a read of it to order its earlier writes.

The translation side takes one request address per cycle. One clock later it returns the physical address and a fault flag.

Top module: `aperture_remap`

## Requirements
- R1: Offset 0x0 is the control register. Bit 0 enables translation, and a read returns the enable in bit 0 with zeros above it.
- R2: Offset 0x4 is the page-select register. It stores all 32 bits written to it, and a read returns them unchanged.
- R3: A write to offset 0x8 stores data bit 31 (valid) and bits 30:12 (page frame) into the entry that page-select names. A read of offset 0x8 returns {valid, frame, 12'h000} for that entry.
- R4: When page-select lies outside the window, writes to offset 0x8 change no entry, and reads of offset 0x8 return zero.
- R5: xl_valid is high exactly one cycle after each cycle in which xl_req is high, and low otherwise.
- R6: A translation that does not fault returns xl_paddr = {1'b0, frame, request bits 11:0}.
- R7: While the enable is 0, every translation faults.
- R8: A request below the base, or at or above base + NUM_ENTRIES*4096, faults. A faulting translation returns xl_paddr = 0.
- R9: A request to an entry whose valid bit is 0 faults. Writing 0 to an entry clears its mapping.
- R10: After reset the enable is 0, page-select is 0 and every entry is invalid with a zero frame.
- R11: The entry index is (address - base) >> 12, for both page-select and requests, so the first and the last page of the window each reach their own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| xl_req | input | 1 | Translation request strobe |
| xl_addr | input | 32 | Request byte address |
| xl_valid | output | 1 | Translation result valid |
| xl_fault | output | 1 | Translation faulted |
| xl_paddr | output | 32 | Translated physical address |

## Verification
The bench builds the block with an eight-entry window based at 0x0010_0000. With so few entries, both window edges can be hit with ordinary constants: the last page 0x0010_7xxx and the first address past the window, 0x0010_8000. The bench also drives an address one byte below the base. The small table lets the bench show that a write through an out-of-window page-select lands in no entry. It also lets the bench check the first and the last entry independently of each other.

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter logic [31:0] APER_BASE   = 32'h4000_0000,
  parameter int          NUM_ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        xl_req,
  input  logic [31:0] xl_addr,
  output logic        xl_valid,
  output logic        xl_fault,
  output logic [31:0] xl_paddr
);
  localparam int          PG_SH      = 12;
  localparam int          FRAME_W    = 31 - PG_SH;
  localparam int          IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [32:0] APER_BYTES = 33'(NUM_ENTRIES) << PG_SH;
  localparam logic [3:0]  OFS_CTRL   = 4'h0;
  localparam logic [3:0]  OFS_SEL    = 4'h4;
  localparam logic [3:0]  OFS_DATA   = 4'h8;

  logic                enable;
  logic [31:0]         page_sel;
  logic                ent_v [NUM_ENTRIES];
  logic [FRAME_W-1:0]  ent_f [NUM_ENTRIES];

  function automatic logic in_window(input logic [31:0] a);
    return (a >= APER_BASE) && (({1'b0, a} - {1'b0, APER_BASE}) < APER_BYTES);
  endfunction

  function automatic logic [IDX_W-1:0] page_index(input logic [31:0] a);
    logic [31:0] d;
    d = a - APER_BASE;
    return d[PG_SH +: IDX_W];
  endfunction

  wire              sel_hit = in_window(page_sel);
  wire [IDX_W-1:0]  sel_idx = page_index(page_sel);
  wire              req_hit = in_window(xl_addr);
  wire [IDX_W-1:0]  req_idx = page_index(xl_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      page_sel <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_CTRL) enable   <= reg_wdata[0];
      if (reg_addr == OFS_SEL)  page_sel <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent_v[i] <= 1'b0;
        ent_f[i] <= '0;
      end
    end else if (reg_wr && reg_addr == OFS_DATA && sel_hit) begin
      ent_v[sel_idx] <= reg_wdata[31];
      ent_f[sel_idx] <= reg_wdata[30:PG_SH];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata = {31'b0, enable};
      OFS_SEL:  reg_rdata = page_sel;
      OFS_DATA: if (sel_hit) reg_rdata = {ent_v[sel_idx], ent_f[sel_idx], {PG_SH{1'b0}}};
      default:  reg_rdata = '0;
    endcase
  end

  wire req_fault = !enable || !req_hit || !ent_v[req_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_fault <= 1'b0;
      xl_paddr <= '0;
    end else begin
      xl_valid <= xl_req;
      if (xl_req) begin
        xl_fault <= req_fault;
        xl_paddr <= req_fault ? 32'h0 : {1'b0, ent_f[req_idx], xl_addr[PG_SH-1:0]};
      end
    end
  end

  assert_valid_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_valid);
  assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> !xl_valid);
  assert_fault_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !enable) |=> xl_fault);
  assert_fault_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !req_hit) |=> (xl_fault && xl_paddr == 32'h0));
  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !req_fault) |=> (!xl_fault && xl_paddr[PG_SH-1:0] == $past(xl_addr[PG_SH-1:0])));
endmodule

// File: tb/aperture_remap_tb_top.sv
`timescale 1ns/1ps
module aperture_remap_tb_top;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam int          NENT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xl_req = 1'b0;
  logic [31:0] xl_addr = '0;
  logic        xl_valid, xl_fault;
  logic [31:0] xl_paddr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  typedef struct { logic fault; logic [31:0] paddr; string tag; } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  aperture_remap #(.APER_BASE(BASE), .NUM_ENTRIES(NENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_req(xl_req),
    .xl_addr(xl_addr), .xl_valid(xl_valid), .xl_fault(xl_fault), .xl_paddr(xl_paddr));

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    vectors++;
    if (reg_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s: reg 0x%0h read 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] a, input logic f, input logic [31:0] pa, input string tag);
    exp_t e;
    e.fault = f; e.paddr = pa; e.tag = tag;
    @(negedge clk);
    expq.push_back(e);
    xl_req = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      if (xl_valid) begin
        vectors++;
        if (expq.size() == 0) begin
          miscompares++;
          $display("FAIL R5: xl_valid=1 expected 0 (no request pending)");
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (xl_fault !== e.fault || xl_paddr !== e.paddr) begin
            miscompares++;
            $display("FAIL %s: fault=%0b paddr=0x%08h expected fault=%0b paddr=0x%08h",
                     e.tag, xl_fault, xl_paddr, e.fault, e.paddr);
          end
        end
      end else if (expq.size() != 0) begin
        vectors++;
        miscompares++;
        $display("FAIL R5: xl_valid=0 expected 1 one cycle after request");
        void'(expq.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(4'h0, 32'h0, "R10 ctrl after reset");
    rd(4'h4, 32'h0, "R10 page-select after reset");
    wr(4'h4, BASE + 32'h3000);
    rd(4'h8, 32'h0, "R10 entry cleared after reset");
    // R7 disabled
    xlate(BASE + 32'h0123, 1'b1, 32'h0, "R7 disabled");
    // R1 enable
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h1, "R1 ctrl readback");
    xlate(BASE + 32'h0123, 1'b1, 32'h0, "R9 invalid entry after reset");
    // R3 first entry
    wr(4'h4, BASE);
    wr(4'h8, 32'h8123_4FFF);
    rd(4'h8, 32'h8123_4000, "R3 entry readback");
    xlate(BASE + 32'h05A5, 1'b0, 32'h0123_45A5, "R6 first page translate");
    // R11 last entry via unaligned select
    wr(4'h4, BASE + 32'h7010);
    rd(4'h4, BASE + 32'h7010, "R2 page-select readback");
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, 32'hFFFF_F000, "R3 last entry readback");
    xlate(BASE + 32'h7FFF, 1'b0, 32'h7FFF_FFFF, "R11 last page translate");
    xlate(BASE + 32'h0001, 1'b0, 32'h0123_4001, "R11 first page unaffected");
    // R8 bounds
    xlate(BASE + 32'h8000, 1'b1, 32'h0, "R8 end of window");
    xlate(BASE - 32'h1, 1'b1, 32'h0, "R8 below base");
    // R4 outside select
    wr(4'h4, 32'h0000_0000);
    wr(4'h8, 32'h8000_5000);
    rd(4'h8, 32'h0, "R4 outside select reads zero");
    wr(4'h4, BASE + 32'h8000);
    wr(4'h8, 32'h8000_6000);
    rd(4'h8, 32'h0, "R4 select at end reads zero");
    wr(4'h4, BASE);
    rd(4'h8, 32'h8123_4000, "R4 entry0 untouched");
    wr(4'h4, BASE + 32'h7000);
    rd(4'h8, 32'hFFFF_F000, "R4 last entry untouched");
    xlate(BASE + 32'h3010, 1'b1, 32'h0, "R9 unmapped middle entry");
    // R9 clear
    wr(4'h4, BASE);
    wr(4'h8, 32'h0);
    rd(4'h8, 32'h0, "R9 cleared entry readback");
    xlate(BASE + 32'h0010, 1'b1, 32'h0, "R9 cleared entry faults");
    // R7 disable then re-enable
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h0, "R1 ctrl cleared");
    xlate(BASE + 32'h7000, 1'b1, 32'h0, "R7 disabled valid entry");
    wr(4'h0, 32'h1);
    xlate(BASE + 32'h7ABC, 1'b0, 32'h7FFF_FABC, "R7 re-enabled");
    // R5 idle gap
    repeat (4) @(negedge clk);
    vectors++;
    if (expq.size() != 0) begin
      miscompares++;
      $display("FAIL R5: %0d results outstanding expected 0", expq.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule